// File: doc/BRIEF.md
# Serial Port Interrupt Register Bank

This block holds the interrupt registers of a serial port. It serves four interrupt sources: transmit watermark, receive watermark, transmit empty and receive overflow. The transmit and receive logic report each of these as a single-cycle event pulse. The pulse sets a sticky pending bit. Software acknowledges a pending bit by writing a one to it. A separate write-only register lets software force pending bits for self-test.

A per-source mask register gates each pending bit onto its own interrupt line. A line is high only while its pending bit and its mask bit are both set. The bank sits on a simple 32-bit word register bus. Writes are taken on the clock edge. Read data is decoded combinationally from the address.

Top module: `irq_reg_bank`

## Requirements
- R1: After reset, the pending register and the mask register read as 0, and every interrupt line is low.
- R2: Interrupt line `irq[i]` is high exactly when pending bit i and mask bit i are both 1. The line follows any change of either bit in the same cycle that the register updates.
- R3: A write to the pending register (offset 0x0) clears each bit whose data bit is 1. Bits written with 0 keep their value.
- R4: A write to the test register (offset 0x8) ORs the data bits into the pending register. A read of offset 0x8 always returns 0.
- R5: The mask register (offset 0x4) is read/write. Its four data bits [3:0] are stored, and bits [31:4] read back as 0.
- R6: An event pulse `hw_evt[i]` sets pending bit i at the next clock edge.
- R7: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R8: Any offset other than 0x0, 0x4 and 0x8, including addresses that are not word-aligned, reads as 0. A write to such an offset changes neither register.
- R9: Bit positions are shared by events, pending, mask, test and lines: bit 0 is transmit watermark, bit 1 is receive watermark, bit 2 is transmit empty and bit 3 is receive overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 10 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hw_evt | input | 4 | Single-cycle event pulses from the transmit and receive logic |
| irq | output | 4 | Interrupt lines, one per source |

## Verification
Two functions can fall in the same cycle: a hardware event and a software acknowledge can both hit one pending bit. The bench provokes this by driving an event pulse during the same cycle as a clearing write to the pending register, with the clear mask covering the event bit and also other bits. It then reads the pending register back. The event bit must still be set, while the other cleared bits must read 0.

// File: rtl/irq_reg_bank.sv
module irq_reg_bank #(
  parameter int NUM_SRC    = 4,
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int STATE_OFF  = 'h0,
  parameter int ENABLE_OFF = 'h4,
  parameter int TEST_OFF   = 'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] hw_evt,
  output logic [NUM_SRC-1:0] irq
);

  logic [NUM_SRC-1:0] state_q, enable_q;
  logic [NUM_SRC-1:0] wbits, clr_mask, force_mask;
  logic sel_state, sel_enable, sel_test;
  logic unused_wdata;

  assign sel_state  = bus_addr == ADDR_W'(STATE_OFF);
  assign sel_enable = bus_addr == ADDR_W'(ENABLE_OFF);
  assign sel_test   = bus_addr == ADDR_W'(TEST_OFF);

  assign wbits        = bus_wdata[NUM_SRC-1:0];
  assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_SRC];

  assign clr_mask   = (bus_we && sel_state) ? wbits : '0;
  assign force_mask = (bus_we && sel_test)  ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= '0;
      enable_q <= '0;
    end else begin
      state_q <= (state_q & ~clr_mask) | force_mask | hw_evt;
      if (bus_we && sel_enable) enable_q <= wbits;
    end
  end

  assign irq = state_q & enable_q;

  always_comb begin
    bus_rdata = '0;
    if (sel_state)       bus_rdata[NUM_SRC-1:0] = state_q;
    else if (sel_enable) bus_rdata[NUM_SRC-1:0] = enable_q;
  end

endmodule

module irq_reg_bank_chk #(
  parameter int NUM_SRC    = 4,
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int STATE_OFF  = 'h0,
  parameter int ENABLE_OFF = 'h4,
  parameter int TEST_OFF   = 'h8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NUM_SRC-1:0] hw_evt,
  input logic [NUM_SRC-1:0] state_q,
  input logic [NUM_SRC-1:0] enable_q,
  input logic [NUM_SRC-1:0] irq
);

  logic a_state, a_enable, a_test;
  logic [NUM_SRC-1:0] wlo;
  assign a_state  = bus_addr == ADDR_W'(STATE_OFF);
  assign a_enable = bus_addr == ADDR_W'(ENABLE_OFF);
  assign a_test   = bus_addr == ADDR_W'(TEST_OFF);
  assign wlo      = bus_wdata[NUM_SRC-1:0];

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (state_q == '0 && enable_q == '0 && irq == '0));

  // R2
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(state_q) && $stable(enable_q)) |-> $stable(irq));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && a_state && (wlo & ~hw_evt) != '0) |=> (state_q & $past(wlo & ~hw_evt)) == '0);

  // R4
  test_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && a_test) |=> (state_q & $past(wlo)) == $past(wlo));

  // R5
  enable_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && a_enable) |=> enable_q == $past(wlo));

  // R6 R7
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt != '0) |=> (state_q & $past(hw_evt)) == $past(hw_evt));

  // R8
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !a_state && !a_enable && !a_test && hw_evt == '0)
      |=> ($stable(state_q) && $stable(enable_q)));

endmodule

bind irq_reg_bank irq_reg_bank_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .STATE_OFF(STATE_OFF), .ENABLE_OFF(ENABLE_OFF), .TEST_OFF(TEST_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .hw_evt(hw_evt), .state_q(state_q),
  .enable_q(enable_q), .irq(irq)
);

// File: tb/irq_reg_bank_bench.sv
module irq_reg_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  hw_evt = '0;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_reg_bank u_irq_reg_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_evt(hw_evt), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic [3:0] ev);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; hw_evt = ev;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0; hw_evt = '0;
  endtask

  task automatic pulse(input logic [3:0] ev);
    @(negedge clk);
    hw_evt = ev;
    @(negedge clk);
    hw_evt = '0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(10'h0, d); check("R1 state", d, 32'h0);
    rd(10'h4, d); check("R1 enable", d, 32'h0);
    check("R1 irq", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      pulse(4'(1 << i));
      rd(10'h0, d); check("R6 R9 event sets bit", d, 32'(1 << i));
      check("R2 irq masked", {28'h0, irq}, 32'h0);
      wr(10'h0, 32'hF, 4'h0);
    end
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(10'h4, 32'hFFFF_FFF5, 4'h0);
    rd(10'h4, d); check("R5 enable readback", d, 32'h5);
    pulse(4'hF);
    check("R2 R9 irq gated", {28'h0, irq}, 32'h5);
    wr(10'h4, 32'h2, 4'h0);
    check("R2 irq follows enable", {28'h0, irq}, 32'h2);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(10'h0, 32'hFFFF_FFF3, 4'h0);
    rd(10'h0, d); check("R3 w1c", d, 32'hC);
    check("R2 irq after clear", {28'h0, irq}, 32'h0);
    wr(10'h0, 32'h0, 4'h0);
    rd(10'h0, d); check("R3 zero write keeps", d, 32'hC);
    wr(10'h0, 32'hF, 4'h0);
  endtask

  task automatic t_test();
    logic [31:0] d;
    wr(10'h8, 32'h3, 4'h0);
    rd(10'h0, d); check("R4 test forces", d, 32'h3);
    check("R2 irq forced", {28'h0, irq}, 32'h2);
    rd(10'h8, d); check("R4 test reads 0", d, 32'h0);
    wr(10'h8, 32'h8, 4'h0);
    rd(10'h0, d); check("R4 test ORs", d, 32'hB);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(10'h0, 32'hF, 4'h2);
    rd(10'h0, d); check("R7 set beats clear", d, 32'h2);
    check("R7 irq kept", {28'h0, irq}, 32'h2);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(10'h0C, 32'hF, 4'h0);
    wr(10'h5, 32'hF, 4'h0);
    wr(10'h1, 32'hF, 4'h0);
    rd(10'h0, d); check("R8 state untouched", d, 32'h2);
    rd(10'h4, d); check("R8 enable untouched", d, 32'h2);
    rd(10'h0C, d); check("R8 unmapped reads 0", d, 32'h0);
    rd(10'h1, d); check("R8 unaligned reads 0", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_events();
    t_enable();
    t_w1c();
    t_test();
    t_collide();
    t_unmapped();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule